// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a synchronous host and an external asynchronous static RAM. The host issues a one-cycle request, either a read or a write, with a 21-bit address and, for writes, an 8-bit data byte. The block then drives the RAM's active-low chip-select, output-enable and write-enable strobes, the address and the outgoing data byte. Each phase is held for a whole number of clock cycles. Every cycle count is derived by a ceiling division of a nanosecond minimum by the clock-period parameter, so one instance meets the part's timing at any clock rate the parameters describe.

Only one access runs at a time. `req_ready` is high only when the block is idle, and a request offered while it is low is dropped. A write ends with a one-cycle `wr_done` pulse. A read ends with a one-cycle `rd_valid` pulse, with the byte that was sampled from the RAM bus on the last cycle of the access window. The bidirectional RAM data bus is split into `sram_dq_out`, `sram_dq_oe` and `sram_dq_in`, and the pad is resolved outside this block. The host's driver is enabled only while the RAM's output enable is inactive, so the two sides never drive the bus at the same time.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `sram_ce_n`, `sram_oe_n` and `sram_we_n` are 1, `sram_dq_oe`, `rd_valid` and `wr_done` are 0, and `req_ready` is 1.
- R2: Whenever `req_ready` is 1, the block is idle: `sram_ce_n` and `sram_we_n` are 1.
- R3: `sram_we_n` is 0 only while `sram_ce_n` is 0 and `sram_oe_n` is 1. Write-enable therefore falls after chip-select falls and rises before chip-select rises.
- R4: Write-enable stays low for NWP cycles, where NWP = max(ceil(55/T), ceil(30/T), ceil(65/T)-1) and T is the clock period in ns. NWP is 16 at T=4.
- R5: `sram_addr` and `sram_dq_out` hold steady while chip-select is low. `sram_addr` equals the accepted request's address from the cycle after acceptance.
- R6: `sram_dq_oe` is 1 only while `sram_oe_n` is 1, and it is 1 for every cycle in which `sram_we_n` is 0.
- R7: A write keeps chip-select low for one setup cycle, then the NWP pulse, then NREC recovery cycles with write-enable high, where NREC = max(ceil(5/T), ceil(70/T)-1-NWP). `wr_done` is high for one cycle, 1+NWP+NREC cycles after the accepting edge (19 at T=4), and `req_ready` returns in that same cycle.
- R8: A read holds chip-select and output-enable low and write-enable high for NRA = ceil(70/T) cycles. `rd_valid` is high for one cycle, NRA cycles after the accepting edge, with `rd_data` equal to the RAM byte present in the last cycle of that window.
- R9: After a read, chip-select and output-enable stay high for NTO = ceil(25/T) cycles before `req_ready` returns. That is NRA+NTO cycles after acceptance (25 at T=4).
- R10: A request presented while `req_ready` is 0 is ignored: the address and strobes of the running access do not change, and no RAM location is written.
- R11: Data written to an address is returned by a later read of that address, including after an overwrite and at the highest address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Request address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Idle and accepting a request |
| rd_valid | output | 1 | One-cycle read completion pulse |
| rd_data | output | 8 | Read data, valid with `rd_valid` |
| wr_done | output | 1 | One-cycle write completion pulse |
| sram_addr | output | 21 | RAM address |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_dq_out | output | 8 | Data driven toward the RAM |
| sram_dq_oe | output | 1 | Enable for the host-side data driver |
| sram_dq_in | input | 8 | Data returned from the RAM bus |

## Verification
The checker watches the strobe relationships on every clock cycle. It confirms that write-enable lies inside the chip-select window with output-enable high, that the data driver never overlaps output-enable, and that address and data stay steady while chip-select is low. It also counts each write-enable pulse against NWP and ties the completion pulses to the phase that precedes them. The exact latencies, the read turnaround gap, the dropping of requests made while busy, and the data actually landing in the RAM can only be seen in the bench scenarios. There a behavioural RAM stores bytes on the rising edge of write-enable and measures the pulse, address-hold and data-setup windows in cycles.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WSET,
    PH_WPUL,
    PH_WREC,
    PH_RACC,
    PH_RTURN
  } phase_t;

  function automatic int cdiv(input int ns, input int per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_addr_data.sv
module sram_addr_data #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              latch,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (latch) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (capture)
      rdata_q <= dq_in;
  end
endmodule

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
  import sram_ctl_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int N_WP  = 16,
  parameter int N_REC = 2,
  parameter int N_RA  = 18,
  parameter int N_TO  = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             expired,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             latch,
  output logic             capture,
  output logic             ready_q,
  output logic             ce_n_q,
  output logic             oe_n_q,
  output logic             we_n_q,
  output logic             dq_oe_q,
  output logic             rd_valid_q,
  output logic             wr_done_q
);
  phase_t ph_q, ph_d;
  logic   fin_wr, fin_rd;

  always_comb begin
    ph_d     = ph_q;
    load     = 1'b0;
    load_val = '0;
    latch    = 1'b0;
    capture  = 1'b0;
    fin_wr   = 1'b0;
    fin_rd   = 1'b0;
    case (ph_q)
      PH_IDLE: if (req_valid) begin
        latch = 1'b1;
        load  = 1'b1;
        if (req_write) begin
          ph_d     = PH_WSET;
          load_val = '0;
        end else begin
          ph_d     = PH_RACC;
          load_val = CNT_W'(N_RA - 1);
        end
      end
      PH_WSET: if (expired) begin
        ph_d     = PH_WPUL;
        load     = 1'b1;
        load_val = CNT_W'(N_WP - 1);
      end
      PH_WPUL: if (expired) begin
        ph_d     = PH_WREC;
        load     = 1'b1;
        load_val = CNT_W'(N_REC - 1);
      end
      PH_WREC: if (expired) begin
        ph_d   = PH_IDLE;
        fin_wr = 1'b1;
      end
      PH_RACC: if (expired) begin
        ph_d     = PH_RTURN;
        load     = 1'b1;
        load_val = CNT_W'(N_TO - 1);
        capture  = 1'b1;
        fin_rd   = 1'b1;
      end
      PH_RTURN: if (expired) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q       <= PH_IDLE;
      ready_q    <= 1'b1;
      ce_n_q     <= 1'b1;
      oe_n_q     <= 1'b1;
      we_n_q     <= 1'b1;
      dq_oe_q    <= 1'b0;
      rd_valid_q <= 1'b0;
      wr_done_q  <= 1'b0;
    end else begin
      ph_q       <= ph_d;
      ready_q    <= (ph_d == PH_IDLE);
      ce_n_q     <= (ph_d == PH_IDLE) || (ph_d == PH_RTURN);
      oe_n_q     <= (ph_d != PH_RACC);
      we_n_q     <= (ph_d != PH_WPUL);
      dq_oe_q    <= (ph_d == PH_WSET) || (ph_d == PH_WPUL) || (ph_d == PH_WREC);
      rd_valid_q <= fin_rd;
      wr_done_q  <= fin_wr;
    end
  end
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W      = 21,
  parameter int DATA_W      = 8,
  parameter int CLK_NS      = 4,
  parameter int WR_CYC_NS   = 70,
  parameter int WR_PULSE_NS = 55,
  parameter int ADDR_END_NS = 65,
  parameter int DATA_END_NS = 30,
  parameter int WR_RECOV_NS = 5,
  parameter int RD_CYC_NS   = 70,
  parameter int RD_OFF_NS   = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_done,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);
  // One setup cycle precedes the pulse, so the address-to-end window needs one fewer.
  localparam int N_WP  = imax(imax(cdiv(WR_PULSE_NS, CLK_NS), cdiv(DATA_END_NS, CLK_NS)),
                              cdiv(ADDR_END_NS, CLK_NS) - 1);
  localparam int N_WC  = cdiv(WR_CYC_NS, CLK_NS);
  localparam int N_REC = imax(cdiv(WR_RECOV_NS, CLK_NS), N_WC - 1 - N_WP);
  localparam int N_RA  = cdiv(RD_CYC_NS, CLK_NS);
  localparam int N_TO  = imax(cdiv(RD_OFF_NS, CLK_NS), 1);
  localparam int N_MAX = imax(imax(N_WP, N_REC), imax(N_RA, N_TO));
  localparam int CNT_W = $clog2(N_MAX + 1);

  logic             load, expired, latch, capture;
  logic [CNT_W-1:0] load_val;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  sram_phase_seq #(
    .CNT_W (CNT_W),
    .N_WP  (N_WP),
    .N_REC (N_REC),
    .N_RA  (N_RA),
    .N_TO  (N_TO)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .expired    (expired),
    .load       (load),
    .load_val   (load_val),
    .latch      (latch),
    .capture    (capture),
    .ready_q    (req_ready),
    .ce_n_q     (sram_ce_n),
    .oe_n_q     (sram_oe_n),
    .we_n_q     (sram_we_n),
    .dq_oe_q    (sram_dq_oe),
    .rd_valid_q (rd_valid),
    .wr_done_q  (wr_done)
  );

  sram_addr_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .latch     (latch),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .capture   (capture),
    .dq_in     (sram_dq_in),
    .addr_q    (sram_addr),
    .wdata_q   (sram_dq_out),
    .rdata_q   (rd_data)
  );
endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 8,
  parameter int N_WP   = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              wr_done,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce_n,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic [DATA_W-1:0] sram_dq_out,
  input logic              sram_dq_oe
);
  logic [15:0] we_low_cnt;

  always_ff @(posedge clk) begin
    if (rst)
      we_low_cnt <= '0;
    else if (sram_we_n)
      we_low_cnt <= '0;
    else if (we_low_cnt != 16'hFFFF)
      we_low_cnt <= we_low_cnt + 1'b1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && !rd_valid && !wr_done && req_ready));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (sram_ce_n && sram_we_n));

  // R3
  we_inside_ce_chk: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> (!sram_ce_n && sram_oe_n));

  // R4
  we_pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> (we_low_cnt >= 16'(N_WP)));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sram_ce_n && !$past(sram_ce_n)) |-> ($stable(sram_addr) && $stable(sram_dq_out)));

  // R6
  no_contention_chk: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> sram_oe_n);

  // R6
  drive_during_we_chk: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> sram_dq_oe);

  // R7
  wr_done_after_recov_chk: assert property (@(posedge clk) disable iff (rst)
    wr_done |-> $past(!sram_ce_n && sram_we_n && sram_dq_oe));

  // R8
  rd_valid_after_window_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(!sram_ce_n && !sram_oe_n && sram_we_n));

  // R9
  turnaround_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (sram_ce_n && sram_oe_n && !req_ready));
endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .N_WP   (N_WP)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_ready   (req_ready),
  .rd_valid    (rd_valid),
  .wr_done     (wr_done),
  .sram_addr   (sram_addr),
  .sram_ce_n   (sram_ce_n),
  .sram_oe_n   (sram_oe_n),
  .sram_we_n   (sram_we_n),
  .sram_dq_out (sram_dq_out),
  .sram_dq_oe  (sram_dq_oe)
);

// File: tb/sram_strobe_ctrl_tb.sv
module sram_strobe_ctrl_tb;
  localparam int AW = 21;
  localparam int DW = 8;
  localparam int TP = 4;

  function automatic int cd(input int ns);
    return (ns + TP - 1) / TP;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_WP   = mx(mx(cd(55), cd(30)), cd(65) - 1);
  localparam int E_REC  = mx(cd(5), cd(70) - 1 - E_WP);
  localparam int E_WLAT = 1 + E_WP + E_REC;
  localparam int E_RD   = cd(70);
  localparam int E_TO   = cd(25);

  // {write, address, data-or-expected}
  localparam int NV = 9;
  localparam logic [AW+DW:0] VEC [NV] = '{
    {1'b1, 21'h000010, 8'hA5},
    {1'b1, 21'h1FFFFF, 8'h3C},
    {1'b1, 21'h100020, 8'h00},
    {1'b1, 21'h0ABC33, 8'hFF},
    {1'b0, 21'h000010, 8'hA5},
    {1'b0, 21'h1FFFFF, 8'h3C},
    {1'b1, 21'h000010, 8'h5A},
    {1'b0, 21'h000010, 8'h5A},
    {1'b0, 21'h0ABC33, 8'hFF}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rd_valid, wr_done;
  logic [DW-1:0] rd_data, sram_dq_out, sram_dq_in;
  logic [AW-1:0] sram_addr;
  logic          sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;

  always #(TP/2) clk = ~clk;

  sram_strobe_ctrl u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_done(wr_done),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
    .sram_dq_in(sram_dq_in)
  );

  // Behavioural RAM indexed by the low address byte; stores at the end of a write.
  logic [DW-1:0] mem [256];
  initial for (int i = 0; i < 256; i++) mem[i] = '0;
  always @(posedge sram_we_n) if (sram_ce_n === 1'b0) mem[sram_addr[7:0]] = sram_dq_out;
  assign sram_dq_in = (!sram_ce_n && !sram_oe_n && sram_we_n) ? mem[sram_addr[7:0]] : '0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Strobe timing monitor, in cycles, sampled away from the active edge
  int we_lo = 0, ce_lo = 0, drv = 0, oe_lo = 0, pulses = 0, reads = 0;
  int v_pulse = 0, v_addr = 0, v_data = 0, v_cont = 0, v_rd = 0, v_rec = 0, rec_cnt = 0;
  logic prev_we = 1'b1, prev_oe = 1'b1, prev_ce = 1'b1;
  logic [AW-1:0] prev_addr = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_we == 1'b0 && sram_we_n == 1'b1) begin
        pulses++;
        if (we_lo < cd(55)) v_pulse++;
        if (ce_lo < cd(65)) v_addr++;
        if (drv < cd(30)) v_data++;
        rec_cnt = 0;
      end
      if (prev_oe == 1'b0 && sram_oe_n == 1'b1) begin
        reads++;
        if (oe_lo < cd(70)) v_rd++;
      end
      if (!sram_ce_n && !prev_ce && sram_addr != prev_addr) v_addr++;
      if (sram_dq_oe && !sram_oe_n) v_cont++;
      if (prev_ce == 1'b0 && sram_ce_n == 1'b1 && pulses > 0 && rec_cnt < cd(5) && prev_oe) v_rec++;
      we_lo = sram_we_n ? 0 : we_lo + 1;
      ce_lo = sram_ce_n ? 0 : ce_lo + 1;
      drv   = sram_dq_oe ? drv + 1 : 0;
      oe_lo = sram_oe_n ? 0 : oe_lo + 1;
      if (!sram_ce_n && sram_we_n) rec_cnt++;
      prev_we = sram_we_n; prev_oe = sram_oe_n; prev_ce = sram_ce_n; prev_addr = sram_addr;
    end
  end

  int op_done, op_ready, op_turn_ok;
  logic [DW-1:0] op_rdata;
  logic [AW-1:0] op_addr_seen;

  task automatic run_op(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int c;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    op_addr_seen = sram_addr;
    c = 0; op_done = 0; op_ready = 0; op_turn_ok = 1; op_rdata = '0;
    while (op_ready == 0 && c < 200) begin
      @(negedge clk);
      c++;
      if ((w ? wr_done : rd_valid) && op_done == 0) begin
        op_done = c;
        op_rdata = rd_data;
      end
      if (!w && op_done != 0 && !req_ready && !(sram_ce_n && sram_oe_n)) op_turn_ok = 0;
      if (req_ready) op_ready = c;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(sram_ce_n && sram_oe_n && sram_we_n, "R1 strobes in reset", {sram_ce_n, sram_oe_n, sram_we_n}, 3'b111);
    chk(!sram_dq_oe && !rd_valid && !wr_done && req_ready, "R1 flags in reset",
        {sram_dq_oe, rd_valid, wr_done, req_ready}, 4'b0001);
    rst = 1'b0;
    @(negedge clk);
    chk(sram_ce_n && req_ready, "R1 after release", {sram_ce_n, req_ready}, 2'b11);

    for (int i = 0; i < NV; i++) begin
      logic          w;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      {w, a, d} = VEC[i];
      run_op(w, a, d);
      chk(op_addr_seen == a, "R5 address presented", op_addr_seen, a);
      if (w) begin
        chk(op_done == E_WLAT, "R7 write done latency", op_done, E_WLAT);
        chk(op_ready == E_WLAT, "R7 ready after write", op_ready, E_WLAT);
      end else begin
        chk(op_done == E_RD, "R8 read valid latency", op_done, E_RD);
        chk(op_rdata == d, "R11 read data", op_rdata, d);
        chk(op_ready == E_RD + E_TO, "R9 ready after turnaround", op_ready, E_RD + E_TO);
        chk(op_turn_ok == 1, "R9 strobes high in turnaround", op_turn_ok, 1);
      end
    end

    // R10: requests while busy are dropped
    begin
      int busy_bad;
      int addr_bad;
      busy_bad = 0;
      addr_bad = 0;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 21'h000040; req_wdata = 8'h11;
      @(negedge clk);
      req_addr = 21'h000041; req_wdata = 8'h77;
      for (int k = 0; k < 8; k++) begin
        if (req_ready) busy_bad++;
        if (sram_addr != 21'h000040 || sram_dq_out != 8'h11) addr_bad++;
        @(negedge clk);
      end
      req_valid = 1'b0;
      chk(busy_bad == 0, "R10 ready low while busy", busy_bad, 0);
      chk(addr_bad == 0, "R10 running access unchanged", addr_bad, 0);
      run_op(1'b0, 21'h000041, 8'h00);
      chk(op_rdata == 8'h00, "R10 dropped write not stored", op_rdata, 8'h00);
      run_op(1'b0, 21'h000040, 8'h00);
      chk(op_rdata == 8'h11, "R11 accepted write stored", op_rdata, 8'h11);
    end

    // R2 idle strobes
    repeat (3) @(negedge clk);
    chk(req_ready && sram_ce_n && sram_we_n, "R2 idle strobes", {req_ready, sram_ce_n, sram_we_n}, 3'b111);

    chk(pulses > 0 && v_pulse == 0, "R4 write pulse width", v_pulse, 0);
    chk(v_addr == 0, "R5 address window and hold", v_addr, 0);
    chk(v_data == 0, "R6 data setup before write end", v_data, 0);
    chk(v_cont == 0, "R6 no bus contention", v_cont, 0);
    chk(v_rec == 0, "R7 recovery after write", v_rec, 0);
    chk(reads > 0 && v_rd == 0, "R8 read window length", v_rd, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule